// File: doc/BRIEF.md
# PHY Management Configuration Sequencer

This block programs an Ethernet PHY over a two-wire clause-22 management bus without any software involvement. After reset it runs a fixed script of register writes once on its own, and it runs the same script again each time `start` is pulsed while it is idle. The script first programs two extended (MMD) registers indirectly. For each one it writes the device number to the access-control register 0x0D in address mode, then the register number to the data register 0x0E. It then switches 0x0D to data mode (0x4000) and puts the value in 0x0E. The two values lengthen the auto-negotiation fast-link-pulse burst spacing to 16 ms.

The script then writes the advertisement register with the asymmetric-pause bit forced to zero. When the `FORCE_MASTER` parameter is set, it writes the 1000BASE-T control register with manual master mode. It ends with a write to the basic control register that restarts auto-negotiation. The management clock is divided down from the system clock so that it never runs faster than `MDC_MAX_HZ`. Data leaves while the clock is low, and the data line is released between frames.

Top module: `mdio_cfg_seq`

## Requirements
- R1: Every write is a 64-bit frame, sent MSB first with `mdio_oe` high for all of it: 32 ones, start 01, write opcode 01, the 5-bit PHY address, the 5-bit register address, turnaround 10, then 16 data bits.
- R2: `mdio_o` and `mdio_oe` change only on a falling edge of `mdc` and hold steady while `mdc` is high, so the PHY samples settled data on the rising edge.
- R3: While busy, each `mdc` half period lasts HALF = ceil(SYS_HZ / (2*MDC_MAX_HZ)) system clocks. While idle, `mdc` is low and `mdio_oe` is low.
- R4: The first eight frames form the indirect extended-register script, given as (register, data): (0x0D,0x0000) (0x0E,0x0004) (0x0D,0x4000) (0x0E,0x0006) (0x0D,0x0000) (0x0E,0x0003) (0x0D,0x4000) (0x0E,0x1A80).
- R5: The ninth frame writes register 0x04 with ADV_VAL and bit 11 cleared.
- R6: If FORCE_MASTER is 1, the tenth frame writes register 0x09 with MS_VAL, bits 12 and 11 set. If FORCE_MASTER is 0, this frame is left out.
- R7: The last frame writes register 0x00 with REG0_VAL, bits 12 and 9 set, which restarts auto-negotiation.
- R8: The script runs once by itself after reset is released, with no `start` pulse.
- R9: A `start` pulse while idle runs the whole script again. A `start` pulse while busy is ignored and is not queued.
- R10: `busy` is high from launch until the falling `mdc` edge that ends the last frame's final bit. `done` is high for exactly one cycle, the first cycle after `busy` falls.
- R11: Between frames, `mdio_oe` is low for GAP_PERIODS full `mdc` periods, at least one.
- R12: `phy_addr` is captured at launch. A change to it during a run does not alter that run's frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to run the script again |
| phy_addr | input | 5 | PHY address, captured at launch |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| busy | output | 1 | Script in progress |
| done | output | 1 | One-cycle pulse when the script ends |

## Verification
The bench decodes every frame from the pins on rising `mdc` and compares it bit for bit with the expected script. A wrong step order, a stray asymmetric-pause bit or a missing restart bit therefore shows up as a mismatched frame. It measures each half period of `mdc` and the released gap between frames. A divider that is off by one, or a gap that vanishes, is reported even though the frames still decode. It pulses `start` during a run and changes `phy_addr` at the same time. A design that queued the request would send a third script, and one that sampled the address live would corrupt the second run's frames.

// File: rtl/mdio_cfg_seq.sv
module mdio_cfg_seq #(
  parameter int          SYS_HZ       = 125_000_000,
  parameter int          MDC_MAX_HZ   = 2_500_000,
  parameter int          GAP_PERIODS  = 2,
  parameter bit          FORCE_MASTER = 1'b1,
  parameter logic [15:0] ADV_VAL      = 16'h0DE1,
  parameter logic [15:0] MS_VAL       = 16'h0200,
  parameter logic [15:0] REG0_VAL     = 16'h0140
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [4:0] phy_addr,
  output logic       mdc,
  output logic       mdio_o,
  output logic       mdio_oe,
  output logic       busy,
  output logic       done
);
  localparam int HALF  = (SYS_HZ + 2*MDC_MAX_HZ - 1) / (2*MDC_MAX_HZ);
  localparam int DW    = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int SLOTS = 64 + GAP_PERIODS;
  localparam int BW    = $clog2(SLOTS);
  localparam int NSTEP = FORCE_MASTER ? 11 : 10;

  logic [DW-1:0] div;
  logic [BW-1:0] bitc;
  logic [3:0]    step;
  logic [4:0]    phy_q;
  logic          run_req;
  logic [4:0]    reg_a;
  logic [15:0]   wdata;
  logic [63:0]   frame;

  wire tick    = (div == DW'(HALF-1));
  wire fall    = busy && tick && mdc;
  wire seq_end = fall && (bitc == BW'(63)) && (step == 4'(NSTEP-1));

  always_comb begin
    reg_a = 5'h00;
    wdata = REG0_VAL | 16'h1200;
    case (step)
      4'd0, 4'd4: begin reg_a = 5'h0D; wdata = 16'h0000; end
      4'd1:       begin reg_a = 5'h0E; wdata = 16'h0004; end
      4'd2, 4'd6: begin reg_a = 5'h0D; wdata = 16'h4000; end
      4'd3:       begin reg_a = 5'h0E; wdata = 16'h0006; end
      4'd5:       begin reg_a = 5'h0E; wdata = 16'h0003; end
      4'd7:       begin reg_a = 5'h0E; wdata = 16'h1A80; end
      4'd8:       begin reg_a = 5'h04; wdata = ADV_VAL & 16'hF7FF; end
      4'd9: if (FORCE_MASTER) begin reg_a = 5'h09; wdata = MS_VAL | 16'h1800; end
      default: ;
    endcase
  end

  assign frame   = {32'hFFFF_FFFF, 4'b0101, phy_q, reg_a, 2'b10, wdata};
  assign mdio_oe = busy && (bitc < BW'(64));
  assign mdio_o  = mdio_oe ? frame[~bitc[5:0]] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div <= '0; bitc <= '0; step <= '0; phy_q <= '0;
      run_req <= 1'b1; mdc <= 1'b0; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start || run_req) begin
          busy <= 1'b1; run_req <= 1'b0; step <= '0; bitc <= '0;
          div <= '0; mdc <= 1'b0; phy_q <= phy_addr;
        end
      end else begin
        div <= tick ? '0 : div + 1'b1;
        if (tick) mdc <= ~mdc;
        if (fall) begin
          if (seq_end) begin
            busy <= 1'b0; done <= 1'b1; bitc <= '0;
          end else if (bitc == BW'(SLOTS-1)) begin
            bitc <= '0; step <= step + 1'b1;
          end else begin
            bitc <= bitc + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_cfg_seq_chk.sv
module mdio_cfg_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic busy,
  input logic done
);
  a_r2_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r1_oe_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);
endmodule

bind mdio_cfg_seq mdio_cfg_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .busy(busy), .done(done)
);

// File: tb/mdio_cfg_seq_tb.sv
module mdio_cfg_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [4:0] phy_addr = 5'h03;
  logic mdc, mdio_o, mdio_oe, busy, done;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_cfg_seq #(
    .SYS_HZ(10_000_000), .MDC_MAX_HZ(2_500_000), .GAP_PERIODS(2),
    .FORCE_MASTER(1'b1), .ADV_VAL(16'h0DE1), .MS_VAL(16'h0200), .REG0_VAL(16'h0140)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .phy_addr(phy_addr),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy), .done(done)
  );

  // expected (register, data) script, R4 R5 R6 R7
  localparam logic [20:0] VEC [10] = '{
    {5'h0D,16'h0000}, {5'h0E,16'h0004}, {5'h0D,16'h4000}, {5'h0E,16'h0006},
    {5'h0D,16'h0000}, {5'h0E,16'h0003}, {5'h0D,16'h4000}, {5'h0E,16'h1A80},
    {5'h04,16'h05E1}, {5'h09,16'h1A00}
  };
  localparam logic [20:0] LAST = {5'h00, 16'h1340};

  int nchk = 0, nfail = 0;
  logic [63:0] frames [0:31];
  int nframes = 0, nbits = 0;
  logic [63:0] shreg = '0;
  logic prev_mdc = 1'b0, prev_mdio = 1'b1, prev_oe = 1'b0;
  int runlen = 0, half_err = 0, stab_err = 0, gaprun = 0, gap_min = 999;
  int done_run = 0, done_err = 0;

  always @(negedge clk) begin
    if (prev_mdc && mdc && (mdio_o != prev_mdio || mdio_oe != prev_oe)) stab_err++;
    if (busy && mdc != prev_mdc) begin
      if (runlen != HALF) half_err++;
      runlen = 1;
    end else if (busy) runlen++;
    else runlen = 0;
    if (mdc && !prev_mdc) begin
      if (mdio_oe) begin
        shreg = {shreg[62:0], mdio_o};
        nbits++;
        if (nbits == 64) begin
          if (nframes < 32) frames[nframes] = shreg;
          nframes++;
          nbits = 0;
        end
      end else if (busy) gaprun++;
    end
    if (mdio_oe && !prev_oe) begin
      if (gaprun > 0 && gaprun < gap_min) gap_min = gaprun;
      gaprun = 0;
    end
    if (!busy) gaprun = 0;
    if (done) begin done_run++; if (done_run > 1) done_err++; end
    else done_run = 0;
    prev_mdc = mdc; prev_mdio = mdio_o; prev_oe = mdio_oe;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mkframe(input logic [4:0] a, input logic [20:0] rd);
    return {32'hFFFF_FFFF, 4'b0101, a, rd[20:16], 2'b10, rd[15:0]};
  endfunction

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 6000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
  endtask

  task automatic check_run(input int base, input logic [4:0] a, input string tag);
    for (int i = 0; i < 10; i++)
      chk($sformatf("%s R1 R4 R5 R6 frame %0d", tag, i), frames[base+i], mkframe(a, VEC[i]));
    chk($sformatf("%s R7 restart frame", tag), frames[base+10], mkframe(a, LAST));
  endtask

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    chk("R3 reset mdc", {63'd0, mdc}, 64'd0);
    chk("R3 reset oe", {63'd0, mdio_oe}, 64'd0);
    chk("R10 reset busy", {63'd0, busy}, 64'd0);
    chk("R10 reset done", {63'd0, done}, 64'd0);
    rst_n = 1'b1;
    wait_done(seen);
    chk("R8 auto run completes", {63'd0, seen}, 64'd1);
    chk("R8 R6 frame count", 64'(nframes), 64'd11);
    check_run(0, 5'h03, "run1");
    chk("R2 data stable while mdc high", 64'(stab_err), 64'd0);
    chk("R3 half period length", 64'(half_err), 64'd0);
    chk("R11 gap periods", 64'(gap_min), 64'd2);
    chk("R10 done width", 64'(done_err), 64'd0);
    repeat (20) @(negedge clk);
    chk("R9 stays idle", {63'd0, busy}, 64'd0);

    phy_addr = 5'h11;
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk("R10 busy after start", {63'd0, busy}, 64'd1);
    repeat (40) @(negedge clk);
    phy_addr = 5'h05;
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done(seen);
    chk("R9 rerun completes", {63'd0, seen}, 64'd1);
    check_run(11, 5'h11, "run2 R12");
    repeat (400) @(negedge clk);
    chk("R9 start while busy not queued", 64'(nframes), 64'd22);
    chk("R3 idle mdc low", {63'd0, mdc}, 64'd0);
    chk("R2 stable run2", 64'(stab_err), 64'd0);
    chk("R3 half run2", 64'(half_err), 64'd0);
    chk("R10 done width run2", 64'(done_err), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog R10 actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule